// File: doc/BRIEF.md
# Register-Controlled Shifter With Carry

This block shifts or rotates a 32-bit operand by an amount held in a register and produces the updated carry flag. It provides four operations: logical left, logical right, arithmetic right and rotate right. Only the low byte of the amount register is used, so an amount can be anywhere from 0 to 255. The carry rules change when the amount is zero, between 1 and 31, exactly 32, or above 32.

The datapath is combinational. A parameter can add one output register stage. With that stage in place, a valid strobe travels with the data and arrives one cycle later. This is the default, and it suits an execute stage whose flags and results are captured at the next clock edge.

Top module: `shift_carry_unit`

## Requirements
- R1: The shift amount is bits [7:0] of `amt_reg`. Bits [31:8] have no effect on the result or the carry.
- R2: For any operation, an amount of 0 returns the operand unchanged, and `carry_out` equals `carry_in`.
- R3: Operation code 2'b00 is logical left. For an amount n from 1 to 31, the result is the operand shifted left by n and the carry is operand bit 32-n. For n = 32, the result is 0 and the carry is operand bit 0. For n above 32, both the result and the carry are 0.
- R4: Operation code 2'b01 is logical right. For an amount n from 1 to 31, the result is the operand shifted right by n with zero fill and the carry is operand bit n-1. For n = 32, the result is 0 and the carry is operand bit 31. For n above 32, both the result and the carry are 0.
- R5: Operation code 2'b10 is arithmetic right. For an amount n from 1 to 31, the operand is shifted right with sign fill and the carry is bit n-1. For n of 32 or more, every result bit and the carry equal operand bit 31.
- R6: Operation code 2'b11 is rotate right. If the amount is non-zero but its bits [4:0] are 0, the result equals the operand and the carry is operand bit 31.
- R7: For rotate right with r = amount bits [4:0] non-zero, the result is the operand rotated right by r and the carry is operand bit r-1.
- R8: With the output register enabled, `out_valid`, `result` and `carry_out` update one clock after their inputs. `out_valid` follows `in_valid` with exactly that one-cycle latency.
- R9: While synchronous reset is high, `out_valid`, `result` and `carry_out` are 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operation is valid |
| operand | input | 32 | Value to shift |
| amt_reg | input | 32 | Register holding the shift amount (low byte used) |
| op_kind | input | 2 | 00 lsl, 01 lsr, 10 asr, 11 ror |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Shifted value |
| carry_out | output | 1 | Updated carry flag |

## Verification
The hardest cases to reach are the carry boundaries: amounts of exactly 32, amounts just above 32, and rotates whose low five bits are zero while the full byte is not, such as 32, 64 and 224. A random amount seldom lands on any of these. The stimulus therefore sweeps every one of the 256 amount values for every operation code, with both carry inputs and several operand patterns. The operand patterns put different values in bits 0, 31 and the middle, so a carry taken from the wrong bit shows up. A second pass repeats the same low bytes with random upper bits in the amount register.

// File: rtl/shc_pkg.sv
package shc_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/shc_amount_decode.sv
module shc_amount_decode #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  localparam int LOG_W = $clog2(DATA_W)
) (
  input  logic [AMT_W-1:0] amt,
  output logic             is_zero,
  output logic             is_below,
  output logic             is_exact,
  output logic             low_zero,
  output logic [LOG_W-1:0] low
);
  localparam logic [AMT_W-1:0] WIDTH_AMT = AMT_W'(DATA_W);

  always_comb begin
    is_zero  = (amt == '0);
    is_below = (amt < WIDTH_AMT);
    is_exact = (amt == WIDTH_AMT);
    low      = amt[LOG_W-1:0];
    low_zero = (low == '0);
  end
endmodule

// File: rtl/shc_core.sv
module shc_core
  import shc_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LOG_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] op,
  input  logic              cin,
  input  shift_kind_e       kind,
  input  logic              is_zero,
  input  logic              is_below,
  input  logic              is_exact,
  input  logic              low_zero,
  input  logic [LOG_W-1:0]  low,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  logic [LOG_W-1:0]    idx_left;
  logic [LOG_W-1:0]    idx_right;
  logic [2*DATA_W-1:0] rot_wide;
  logic                sign_b;

  always_comb begin
    idx_left  = '0 - low;
    idx_right = low - LOG_W'(1);
    rot_wide  = {op, op} >> low;
    sign_b    = op[DATA_W-1];
    res       = op;
    cout      = cin;
    if (!is_zero) begin
      unique case (kind)
        SK_LSL: begin
          if (is_below) begin
            res  = op << low;
            cout = op[idx_left];
          end else begin
            res  = '0;
            cout = is_exact ? op[0] : 1'b0;
          end
        end
        SK_LSR: begin
          if (is_below) begin
            res  = op >> low;
            cout = op[idx_right];
          end else begin
            res  = '0;
            cout = is_exact ? sign_b : 1'b0;
          end
        end
        SK_ASR: begin
          if (is_below) begin
            res  = DATA_W'($signed(op) >>> low);
            cout = op[idx_right];
          end else begin
            res  = {DATA_W{sign_b}};
            cout = sign_b;
          end
        end
        default: begin
          if (low_zero) begin
            res  = op;
            cout = sign_b;
          end else begin
            res  = rot_wide[DATA_W-1:0];
            cout = op[idx_right];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/shc_out_stage.sv
module shc_out_stage #(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              v_in,
  input  logic [DATA_W-1:0] d_in,
  input  logic              c_in,
  output logic              v_out,
  output logic [DATA_W-1:0] d_out,
  output logic              c_out
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          v_out <= 1'b0;
          d_out <= '0;
          c_out <= 1'b0;
        end else begin
          v_out <= v_in;
          d_out <= d_in;
          c_out <= c_in;
        end
      end
    end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst;
      assign v_out = v_in;
      assign d_out = d_in;
      assign c_out = c_in;
    end
  endgenerate
endmodule

// File: rtl/shift_carry_unit.sv
module shift_carry_unit
  import shc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int LOG_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] amt_reg,
  input  logic [1:0]        op_kind,
  input  logic              carry_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);
  logic [AMT_W-1:0]  amt;
  logic              unused_amt_hi;
  logic              a_zero, a_below, a_exact, a_low_zero;
  logic [LOG_W-1:0]  a_low;
  logic [DATA_W-1:0] core_res;
  logic              core_c;

  assign amt           = amt_reg[AMT_W-1:0];    // R1: low byte only
  assign unused_amt_hi = ^amt_reg[DATA_W-1:AMT_W];

  shc_amount_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dec (
    .amt(amt), .is_zero(a_zero), .is_below(a_below), .is_exact(a_exact),
    .low_zero(a_low_zero), .low(a_low)
  );

  shc_core #(.DATA_W(DATA_W)) u_core (
    .op(operand), .cin(carry_in), .kind(shift_kind_e'(op_kind)),
    .is_zero(a_zero), .is_below(a_below), .is_exact(a_exact),
    .low_zero(a_low_zero), .low(a_low), .res(core_res), .cout(core_c)
  );

  shc_out_stage #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst(rst), .v_in(in_valid), .d_in(core_res), .c_in(core_c),
    .v_out(out_valid), .d_out(result), .c_out(carry_out)
  );

  generate
    if (REG_OUT) begin : g_chk
      p_zero_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && amt == '0) |=>
          (result == $past(operand) && carry_out == $past(carry_in)));

      p_lsl_far_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_kind == SK_LSL && amt > AMT_W'(DATA_W)) |=>
          (result == '0 && !carry_out));

      p_lsr_far_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_kind == SK_LSR && amt > AMT_W'(DATA_W)) |=>
          (result == '0 && !carry_out));

      p_asr_fill_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_kind == SK_ASR && amt >= AMT_W'(DATA_W)) |=>
          (result == {DATA_W{$past(operand[DATA_W-1])}} &&
           carry_out == $past(operand[DATA_W-1])));

      p_ror_whole_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_kind == SK_ROR && amt != '0 && amt[LOG_W-1:0] == '0) |=>
          (result == $past(operand) && carry_out == $past(operand[DATA_W-1])));

      p_valid_rise_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

      p_valid_fall_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    end
  endgenerate
endmodule

// File: tb/shift_carry_unit_tb.sv
module shift_carry_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] operand = '0;
  logic [31:0] amt_reg = '0;
  logic [1:0]  op_kind = '0;
  logic        carry_in = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        carry_out;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_carry_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
    .amt_reg(amt_reg), .op_kind(op_kind), .carry_in(carry_in),
    .out_valid(out_valid), .result(result), .carry_out(carry_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      bad = bad + 1;
      $display("FAIL watchdog expired got cycles=%0d exp below %0d", cycles, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Reference model using wide-word arithmetic
  task automatic model(input logic [31:0] op, input logic [7:0] n,
                       input logic [1:0] k, input logic ci,
                       output logic [31:0] r, output logic c);
    logic [63:0] t;
    logic [4:0]  rr;
    r = op; c = ci;
    if (n != 0) begin
      case (k)
        2'b00: begin t = {32'h0, op} << n; r = t[31:0]; c = t[32]; end
        2'b01: begin t = {op, 32'h0} >> n; r = t[63:32]; c = t[31]; end
        2'b10: begin t = 64'($signed({op, 32'h0}) >>> n); r = t[63:32]; c = t[31]; end
        default: begin
          rr = n[4:0];
          t = {op, op} >> rr;
          r = t[31:0];
          c = r[31];
        end
      endcase
    end
  endtask

  function automatic string req_of(input logic [7:0] n, input logic [1:0] k);
    if (n == 0) return "R2";
    case (k)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return (n[4:0] == 0) ? "R6" : "R7";
    endcase
  endfunction

  task automatic apply(input logic [31:0] op, input logic [31:0] ar,
                       input logic [1:0] k, input logic ci, input string tag);
    logic [31:0] er;
    logic        ec;
    @(negedge clk);
    in_valid = 1'b1; operand = op; amt_reg = ar; op_kind = k; carry_in = ci;
    model(op, ar[7:0], k, ci, er, ec);
    @(posedge clk); #1;
    total++;
    if (result !== er || carry_out !== ec || out_valid !== 1'b1) begin
      bad++;
      $display("FAIL %s op=%h amt=%h k=%0d got res=%h c=%b v=%b exp res=%h c=%b v=1",
               tag, op, ar, k, result, carry_out, out_valid, er, ec);
    end
  endtask

  logic [31:0] pats [6] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001,
                            32'h7FFF_FFFE, 32'hA5C3_0F96, 32'h1234_5678};

  initial begin
    // R9: reset state
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (out_valid !== 1'b0 || result !== '0 || carry_out !== 1'b0) begin
      bad++;
      $display("FAIL R9 got v=%b res=%h c=%b exp v=0 res=0 c=0", out_valid, result, carry_out);
    end
    @(negedge clk); rst = 1'b0;

    // R2..R7: full amount sweep for every operation
    for (int k = 0; k < 4; k++)
      for (int p = 0; p < 6; p++)
        for (int ci = 0; ci < 2; ci++)
          for (int n = 0; n < 256; n++)
            apply(pats[p], 32'(n), 2'(k), 1'(ci), req_of(8'(n), 2'(k)));

    // R1: upper bits of amount register ignored
    for (int i = 0; i < 600; i++) begin
      logic [31:0] ar;
      ar = $urandom;
      apply(32'($urandom), ar, 2'(i % 4), 1'(i % 2), "R1");
    end

    // R8: valid drops one cycle after in_valid drops
    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R8 got out_valid=%b exp 0", out_valid);
    end
    @(negedge clk); in_valid = 1'b1;
    #1;
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R8 early got out_valid=%b exp 0", out_valid);
    end
    @(posedge clk); #1;
    total++;
    if (out_valid !== 1'b1) begin
      bad++;
      $display("FAIL R8 got out_valid=%b exp 1", out_valid);
    end

    // R9: reset mid-run clears outputs
    @(negedge clk); rst = 1'b1; operand = 32'hFFFF_FFFF; amt_reg = 0; carry_in = 1'b1;
    @(posedge clk); #1;
    total++;
    if (out_valid !== 1'b0 || result !== '0 || carry_out !== 1'b0) begin
      bad++;
      $display("FAIL R9 got v=%b res=%h c=%b exp v=0 res=0 c=0", out_valid, result, carry_out);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule